// File: doc/BRIEF.md
# Coarse Motion Search Engine

This block runs the first, coarse step of a hierarchical block-matching motion search for one macroblock. Pixels reach it already thinned to every second sample in the horizontal direction, for luma and chroma alike. The block reads an 8×8 current block of these samples and a reference search window from local buffer RAMs. It evaluates every integer displacement from −14 to +14 on both axes. Eight parallel processing elements each form one absolute difference per cycle, so each cycle produces the difference sum of one block row against one candidate.

Once the search ends, the engine measures how far the current block strays from its own mean. From that it decides intra or inter coding. It also decides whether the later fine search can be skipped, by comparing its best SAD with the largest SAD of the left, upper and upper-right neighbours, which the controller supplies. A run takes a fixed number of cycles from start to a one-cycle done pulse, so a scheduler can give it a fixed time slot. The reference window comes from a buffer that already holds the padded picture edge, so a vector may point outside the picture.

Top module: `cme_coarse`

## Requirements
- R1: After reset, `done` is low and `mvX`, `mvY`, `minSad`, `intraFlag` and `skipFine` are all zero.
- R2: A `start` seen while the engine is idle begins a run. `done` is high for exactly one cycle, 6746 clock edges after the edge that accepted `start` (842 candidates × 8 rows + 8 deviation rows + 2), and a `start` during a run is ignored.
- R3: `minSad` is the smallest sum over the 64 samples of |cur[r][c] − win[dy+14+r][dx+14+c]| for dx, dy in −14..14. Current row r is read at `curRowAddr`=r. A reference row segment is read at `refRowAddr`=dy+14+r, `refColAddr`=dx+14. Both RAMs answer on the clock edge after the address, and sample k sits at bits [8k+7:8k].
- R4: `mvX`/`mvY` give the displacement (dx, dy) of that minimum as two's complement. On equal SAD the zero vector wins first, then the earliest candidate in the scan with dy ascending as the outer loop and dx ascending as the inner loop.
- R5: `intraFlag` is 1 exactly when D + `intraBias` < `minSad`. D is the sum of |cur − m| over the block, and m is the floor of the block sum divided by 64.
- R6: `skipFine` is 1 exactly when `minSad` ≤ the largest neighbour SAD. `nbValid` bit 0 marks the left value, bit 1 the upper value and bit 2 the upper-right value, and a neighbour whose bit is 0 counts as 16383.
- R7: Neighbour SADs, their valid bits and `intraBias` are taken when `start` is accepted, and changes to them during a run do not affect its results.
- R8: Result outputs change only on the edge that raises `done` and hold their values until the next `done`, including while a new run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search when idle |
| nbSadLeft | input | 14 | SAD of the left neighbour macroblock |
| nbSadUp | input | 14 | SAD of the upper neighbour |
| nbSadUpRight | input | 14 | SAD of the upper-right neighbour |
| nbValid | input | 3 | Per-neighbour valid bits (0 left, 1 up, 2 up-right) |
| intraBias | input | 14 | Bias used in the intra decision |
| curRowAddr | output | 3 | Current-block row address |
| curRowData | input | 64 | Eight current samples, one clock after address |
| refRowAddr | output | 6 | Reference window row |
| refColAddr | output | 6 | Reference window first column |
| refRowData | input | 64 | Eight window samples from that column on, one clock after address |
| done | output | 1 | One-cycle completion pulse |
| mvX | output | 5 | Horizontal coarse vector, signed |
| mvY | output | 5 | Vertical coarse vector, signed |
| minSad | output | 14 | Best SAD found |
| intraFlag | output | 1 | Intra coding chosen |
| skipFine | output | 1 | Fine search may be skipped |

## Verification
The bench asserts `start` in the very cycle in which `done` pulses. The engine then publishes one set of results and accepts the next run on consecutive edges. A behavioural model, updated every clock, predicts whether the new run begins exactly one edge after the pulse and where its own pulse falls. The same model requires the results just published to stay fixed through the whole following run. A second case changes the neighbour SADs and bias in mid-run and pulses `start` again at that point. The cycle model then requires both the timing and the results to follow the first start alone.

// File: rtl/cme_pkg.sv
package cme_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DEV,
    ST_DRAIN,
    ST_FIN
  } cme_state_t;

  // Strobes from control to datapath. latch and finish are combinational;
  // the others travel one cycle behind the addresses, aligned with RAM data.
  typedef struct packed {
    logic latch;
    logic valid;
    logic firstRow;
    logic lastRow;
    logic firstCand;
    logic devMode;
    logic finish;
  } cme_strobe_t;

endpackage

// File: rtl/cme_ctrl.sv
module cme_ctrl
  import cme_pkg::*;
#(
  parameter int BLK   = 8,
  parameter int RANGE = 14,
  parameter int MV_W  = 5,
  parameter int CW    = 6,
  parameter int ROW_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  output cme_strobe_t            stb,
  output logic signed [MV_W-1:0] candDx,
  output logic signed [MV_W-1:0] candDy,
  output logic [ROW_W-1:0]       curRowAddr,
  output logic [CW-1:0]          refRowAddr,
  output logic [CW-1:0]          refColAddr,
  output logic                   done
);

  localparam int SPAN  = 2 * RANGE;
  localparam int WIN   = BLK + SPAN;
  localparam int IDX_W = $clog2(SPAN + 1);

  cme_state_t       state;
  logic [ROW_W-1:0] row;
  logic [IDX_W-1:0] dxIdx, dyIdx;
  logic             zeroPh;
  logic             doneQ;
  logic             vQ, frQ, lrQ, fcQ, dvQ;

  logic issue, rowLast;
  assign issue   = (state == ST_SCAN) || (state == ST_DEV);
  assign rowLast = (row == ROW_W'(BLK - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      row    <= '0;
      dxIdx  <= '0;
      dyIdx  <= '0;
      zeroPh <= 1'b0;
      doneQ  <= 1'b0;
      vQ     <= 1'b0;
      frQ    <= 1'b0;
      lrQ    <= 1'b0;
      fcQ    <= 1'b0;
      dvQ    <= 1'b0;
      candDx <= '0;
      candDy <= '0;
    end else begin
      doneQ  <= (state == ST_FIN);
      vQ     <= issue;
      frQ    <= (row == '0);
      lrQ    <= rowLast;
      fcQ    <= (state == ST_SCAN) && zeroPh;
      dvQ    <= (state == ST_DEV);
      candDx <= MV_W'(dxIdx) - MV_W'(RANGE);
      candDy <= MV_W'(dyIdx) - MV_W'(RANGE);
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SCAN;
            row    <= '0;
            zeroPh <= 1'b1;
            dxIdx  <= IDX_W'(RANGE);
            dyIdx  <= IDX_W'(RANGE);
          end
        end
        ST_SCAN: begin
          row <= row + ROW_W'(1);
          if (rowLast) begin
            row <= '0;
            if (zeroPh) begin
              zeroPh <= 1'b0;
              dxIdx  <= '0;
              dyIdx  <= '0;
            end else if (dxIdx == IDX_W'(SPAN)) begin
              dxIdx <= '0;
              if (dyIdx == IDX_W'(SPAN)) state <= ST_DEV;
              else dyIdx <= dyIdx + IDX_W'(1);
            end else begin
              dxIdx <= dxIdx + IDX_W'(1);
            end
          end
        end
        ST_DEV: begin
          row <= row + ROW_W'(1);
          if (rowLast) begin
            row   <= '0;
            state <= ST_DRAIN;
          end
        end
        ST_DRAIN: state <= ST_FIN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.latch     = (state == ST_IDLE) && start;
    stb.valid     = vQ;
    stb.firstRow  = frQ;
    stb.lastRow   = lrQ;
    stb.firstCand = fcQ;
    stb.devMode   = dvQ;
    stb.finish    = (state == ST_FIN);
  end

  assign curRowAddr = row;
  assign refRowAddr = CW'(dyIdx) + CW'(row);
  assign refColAddr = CW'(dxIdx);
  assign done       = doneQ;

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: every issued reference read stays inside the search window
  p_ref_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> (refRowAddr <= CW'(WIN - 1)) && (refColAddr <= CW'(SPAN)));

endmodule

// File: rtl/cme_dp.sv
module cme_dp
  import cme_pkg::*;
#(
  parameter int BLK   = 8,
  parameter int PIX_W = 8,
  parameter int SAD_W = 14,
  parameter int MV_W  = 5,
  parameter int RANGE = 14
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cme_strobe_t            stb,
  input  logic signed [MV_W-1:0] candDx,
  input  logic signed [MV_W-1:0] candDy,
  input  logic [BLK*PIX_W-1:0]   curRowData,
  input  logic [BLK*PIX_W-1:0]   refRowData,
  input  logic [SAD_W-1:0]       nbSadLeft,
  input  logic [SAD_W-1:0]       nbSadUp,
  input  logic [SAD_W-1:0]       nbSadUpRight,
  input  logic [2:0]             nbValid,
  input  logic [SAD_W-1:0]       intraBias,
  output logic signed [MV_W-1:0] mvX,
  output logic signed [MV_W-1:0] mvY,
  output logic [SAD_W-1:0]       minSad,
  output logic                   intraFlag,
  output logic                   skipFine
);

  localparam int ROW_SUM_W = PIX_W + $clog2(BLK);
  localparam int CNT_LOG   = $clog2(BLK * BLK);

  logic [PIX_W-1:0]     absd  [BLK];
  logic [PIX_W-1:0]     curPx [BLK];
  logic [PIX_W-1:0]     meanQ;
  logic [ROW_SUM_W-1:0] rowSad, rowCur;
  logic [SAD_W-1:0]     acc, accNext, curSum, curSumNext, devSum, bestSad;
  logic signed [MV_W-1:0] bestDx, bestDy;
  logic [SAD_W-1:0]     nbL, nbU, nbUR, biasQ;
  logic [2:0]           nbValidQ;
  logic [SAD_W-1:0]     effL, effU, effUR, nbMax;

  // Processing elements: one absolute difference per lane per cycle
  for (genvar k = 0; k < BLK; k++) begin : g_pe
    logic [PIX_W-1:0] opnd;
    assign curPx[k] = curRowData[k*PIX_W +: PIX_W];
    assign opnd     = stb.devMode ? meanQ : refRowData[k*PIX_W +: PIX_W];
    assign absd[k]  = (curPx[k] >= opnd) ? (curPx[k] - opnd) : (opnd - curPx[k]);
  end

  always_comb begin
    rowSad = '0;
    rowCur = '0;
    for (int k = 0; k < BLK; k++) begin
      rowSad = rowSad + ROW_SUM_W'(absd[k]);
      rowCur = rowCur + ROW_SUM_W'(curPx[k]);
    end
  end

  assign accNext    = stb.firstRow ? SAD_W'(rowSad) : acc + SAD_W'(rowSad);
  assign curSumNext = stb.firstRow ? SAD_W'(rowCur) : curSum + SAD_W'(rowCur);

  assign effL  = nbValidQ[0] ? nbL  : '1;
  assign effU  = nbValidQ[1] ? nbU  : '1;
  assign effUR = nbValidQ[2] ? nbUR : '1;

  always_comb begin
    nbMax = effL;
    if (effU > nbMax)  nbMax = effU;
    if (effUR > nbMax) nbMax = effUR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      curSum    <= '0;
      meanQ     <= '0;
      devSum    <= '0;
      bestSad   <= '0;
      bestDx    <= '0;
      bestDy    <= '0;
      nbL       <= '0;
      nbU       <= '0;
      nbUR      <= '0;
      nbValidQ  <= '0;
      biasQ     <= '0;
      mvX       <= '0;
      mvY       <= '0;
      minSad    <= '0;
      intraFlag <= 1'b0;
      skipFine  <= 1'b0;
    end else begin
      if (stb.latch) begin
        nbL      <= nbSadLeft;
        nbU      <= nbSadUp;
        nbUR     <= nbSadUpRight;
        nbValidQ <= nbValid;
        biasQ    <= intraBias;
      end
      if (stb.valid) begin
        acc <= accNext;
        if (stb.firstCand) begin
          curSum <= curSumNext;
          if (stb.lastRow) meanQ <= PIX_W'(curSumNext >> CNT_LOG);
        end
        if (stb.lastRow && !stb.devMode && (stb.firstCand || accNext < bestSad)) begin
          bestSad <= accNext;
          bestDx  <= candDx;
          bestDy  <= candDy;
        end
        if (stb.lastRow && stb.devMode) devSum <= accNext;
      end
      if (stb.finish) begin
        mvX       <= bestDx;
        mvY       <= bestDy;
        minSad    <= bestSad;
        intraFlag <= ({1'b0, devSum} + {1'b0, biasQ}) < {1'b0, bestSad};
        skipFine  <= (bestSad <= nbMax);
      end
    end
  end

  // R4: reported vector never leaves the search range
  p_mv_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mvX <= $signed(MV_W'(RANGE))) && (mvX >= -$signed(MV_W'(RANGE))) &&
    (mvY <= $signed(MV_W'(RANGE))) && (mvY >= -$signed(MV_W'(RANGE))));

  // R6: a missing neighbour always permits skipping the fine search
  p_skip_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.finish) && !(&nbValidQ)) |-> skipFine);

  // R5: intra can only be chosen when the best SAD exceeds the bias
  p_intra_bias_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.finish) |-> (!intraFlag || (minSad > biasQ)));

endmodule

// File: rtl/cme_coarse.sv
module cme_coarse
  import cme_pkg::*;
#(
  parameter int BLK   = 8,
  parameter int RANGE = 14,
  parameter int PIX_W = 8
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         start,
  input  logic [PIX_W+$clog2(BLK*BLK)-1:0]             nbSadLeft,
  input  logic [PIX_W+$clog2(BLK*BLK)-1:0]             nbSadUp,
  input  logic [PIX_W+$clog2(BLK*BLK)-1:0]             nbSadUpRight,
  input  logic [2:0]                                   nbValid,
  input  logic [PIX_W+$clog2(BLK*BLK)-1:0]             intraBias,
  output logic [$clog2(BLK)-1:0]                       curRowAddr,
  input  logic [BLK*PIX_W-1:0]                         curRowData,
  output logic [$clog2(BLK+2*RANGE)-1:0]               refRowAddr,
  output logic [$clog2(BLK+2*RANGE)-1:0]               refColAddr,
  input  logic [BLK*PIX_W-1:0]                         refRowData,
  output logic                                         done,
  output logic signed [$clog2(RANGE+1):0]              mvX,
  output logic signed [$clog2(RANGE+1):0]              mvY,
  output logic [PIX_W+$clog2(BLK*BLK)-1:0]             minSad,
  output logic                                         intraFlag,
  output logic                                         skipFine
);

  localparam int SAD_W = PIX_W + $clog2(BLK * BLK);
  localparam int MV_W  = $clog2(RANGE + 1) + 1;
  localparam int WIN   = BLK + 2 * RANGE;
  localparam int CW    = $clog2(WIN);
  localparam int ROW_W = $clog2(BLK);

  cme_strobe_t            stb;
  logic signed [MV_W-1:0] candDx, candDy;

  cme_ctrl #(
    .BLK(BLK), .RANGE(RANGE), .MV_W(MV_W), .CW(CW), .ROW_W(ROW_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .stb(stb),
    .candDx(candDx), .candDy(candDy),
    .curRowAddr(curRowAddr), .refRowAddr(refRowAddr), .refColAddr(refColAddr),
    .done(done)
  );

  cme_dp #(
    .BLK(BLK), .PIX_W(PIX_W), .SAD_W(SAD_W), .MV_W(MV_W), .RANGE(RANGE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .candDx(candDx), .candDy(candDy),
    .curRowData(curRowData), .refRowData(refRowData),
    .nbSadLeft(nbSadLeft), .nbSadUp(nbSadUp), .nbSadUpRight(nbSadUpRight),
    .nbValid(nbValid), .intraBias(intraBias),
    .mvX(mvX), .mvY(mvY), .minSad(minSad), .intraFlag(intraFlag), .skipFine(skipFine)
  );

  // R8: results move only together with the done pulse
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(minSad) && $stable(mvX) && $stable(mvY) &&
               $stable(intraFlag) && $stable(skipFine)));

endmodule

// File: tb/cme_coarse_tb_top.sv
module cme_coarse_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BLK   = 8;
  localparam int RANGE = 14;
  localparam int PIX_W = 8;
  localparam int WIN   = BLK + 2 * RANGE;
  localparam int NCAND = (2 * RANGE + 1) * (2 * RANGE + 1) + 1;
  localparam int LAT   = NCAND * BLK + BLK + 2;
  localparam int SADMAX = 16383;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [13:0] nbSadLeft = '0, nbSadUp = '0, nbSadUpRight = '0, intraBias = '0;
  logic [2:0]  nbValid = '0;
  logic [2:0]  curRowAddr;
  logic [5:0]  refRowAddr, refColAddr;
  logic [BLK*PIX_W-1:0] curRowData = '0, refRowData = '0;
  logic done, intraFlag, skipFine;
  logic signed [4:0] mvX, mvY;
  logic [13:0] minSad;

  logic [7:0] curMem [BLK][BLK];
  logic [7:0] refMem [WIN][WIN];

  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cme_coarse dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .nbSadLeft(nbSadLeft), .nbSadUp(nbSadUp), .nbSadUpRight(nbSadUpRight),
    .nbValid(nbValid), .intraBias(intraBias),
    .curRowAddr(curRowAddr), .curRowData(curRowData),
    .refRowAddr(refRowAddr), .refColAddr(refColAddr), .refRowData(refRowData),
    .done(done), .mvX(mvX), .mvY(mvY), .minSad(minSad),
    .intraFlag(intraFlag), .skipFine(skipFine)
  );

  // Buffer RAMs with one-cycle read latency
  always @(posedge clk) begin
    for (int k = 0; k < BLK; k++) begin
      curRowData[k*PIX_W +: PIX_W] <= curMem[curRowAddr][k];
      refRowData[k*PIX_W +: PIX_W] <= refMem[refRowAddr][refColAddr + k];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Behavioural reference model
  int pSad, pDx, pDy, pIntra, pSkip;
  int eSad = 0, eDx = 0, eDy = 0, eIntra = 0, eSkip = 0;
  bit eDone = 0, busy = 0;
  int cnt = 0;

  task automatic computeModel();
    int best, bdx, bdy, s, sum, mean, dev, mx, v;
    best = -1; bdx = 0; bdy = 0;
    for (int c = -1; c < (2*RANGE+1)*(2*RANGE+1); c++) begin
      int dx, dy;
      dx = (c < 0) ? 0 : (c % (2*RANGE+1)) - RANGE;
      dy = (c < 0) ? 0 : (c / (2*RANGE+1)) - RANGE;
      s = 0;
      for (int r = 0; r < BLK; r++)
        for (int q = 0; q < BLK; q++) begin
          v = int'(curMem[r][q]) - int'(refMem[dy+RANGE+r][dx+RANGE+q]);
          s += (v < 0) ? -v : v;
        end
      if (best < 0 || s < best) begin best = s; bdx = dx; bdy = dy; end
    end
    sum = 0;
    for (int r = 0; r < BLK; r++) for (int q = 0; q < BLK; q++) sum += curMem[r][q];
    mean = sum / (BLK*BLK);
    dev = 0;
    for (int r = 0; r < BLK; r++)
      for (int q = 0; q < BLK; q++) begin
        v = int'(curMem[r][q]) - mean;
        dev += (v < 0) ? -v : v;
      end
    mx = nbValid[0] ? int'(nbSadLeft) : SADMAX;
    if ((nbValid[1] ? int'(nbSadUp) : SADMAX) > mx) mx = nbValid[1] ? int'(nbSadUp) : SADMAX;
    if ((nbValid[2] ? int'(nbSadUpRight) : SADMAX) > mx) mx = nbValid[2] ? int'(nbSadUpRight) : SADMAX;
    pSad = best; pDx = bdx; pDy = bdy;
    pIntra = (dev + int'(intraBias) < best) ? 1 : 0;
    pSkip  = (best <= mx) ? 1 : 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      busy = 0; cnt = 0; eDone = 0;
      eSad = 0; eDx = 0; eDy = 0; eIntra = 0; eSkip = 0;
    end else begin
      eDone = 0;
      if (busy) begin
        cnt++;
        if (cnt == LAT) begin
          eDone = 1; busy = 0;
          eSad = pSad; eDx = pDx; eDy = pDy; eIntra = pIntra; eSkip = pSkip;
        end
      end else if (start) begin
        busy = 1; cnt = 0;
        computeModel();
      end
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(done == eDone, "R2 done timing", int'(done), int'(eDone));
      check(int'(minSad) == eSad, "R3 minSad", int'(minSad), eSad);
      check(int'(mvX) == eDx && int'(mvY) == eDy, "R4 vector (x*100+y)",
            int'(mvX)*100 + int'(mvY), eDx*100 + eDy);
      check(int'(intraFlag) == eIntra, "R5 intraFlag", int'(intraFlag), eIntra);
      check(int'(skipFine) == eSkip, "R6 skipFine", int'(skipFine), eSkip);
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic randWindow();
    for (int r = 0; r < WIN; r++) for (int q = 0; q < WIN; q++) refMem[r][q] = 8'($urandom);
  endtask

  task automatic plant(input int dy, input int dx);
    for (int r = 0; r < BLK; r++)
      for (int q = 0; q < BLK; q++) refMem[dy+RANGE+r][dx+RANGE+q] = curMem[r][q];
  endtask

  task automatic smoothCur();
    for (int r = 0; r < BLK; r++) for (int q = 0; q < BLK; q++) curMem[r][q] = 8'(100 + (r + q) % 3);
  endtask

  task automatic setNb(input int l, input int u, input int ur, input logic [2:0] v, input int b);
    nbSadLeft = 14'(l); nbSadUp = 14'(u); nbSadUpRight = 14'(ur); nbValid = v; intraBias = 14'(b);
  endtask

  task automatic runCase();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (LAT + 2) @(negedge clk);
  endtask

  int keepSad, keepDx, keepDy;

  initial begin
    for (int r = 0; r < BLK; r++) for (int q = 0; q < BLK; q++) curMem[r][q] = '0;
    for (int r = 0; r < WIN; r++) for (int q = 0; q < WIN; q++) refMem[r][q] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(minSad == '0 && mvX == '0 && mvY == '0, "R1 results after reset", int'(minSad), 0);
    check(intraFlag == 1'b0 && skipFine == 1'b0, "R1 flags after reset",
          int'({intraFlag, skipFine}), 0);

    // A: exact match planted at dx=-5, dy=3
    randWindow();
    for (int r = 0; r < BLK; r++) for (int q = 0; q < BLK; q++) curMem[r][q] = refMem[3+RANGE+r][-5+RANGE+q];
    setNb(500, 600, 700, 3'b111, 0);
    runCase();
    check(minSad == '0, "R3 planted match SAD", int'(minSad), 0);
    check(mvX == -5 && mvY == 3, "R4 planted vector (x*100+y)", int'(mvX)*100 + int'(mvY), -497);

    // B: flat picture, every candidate ties -> zero vector
    for (int r = 0; r < WIN; r++) for (int q = 0; q < WIN; q++) refMem[r][q] = 8'd77;
    for (int r = 0; r < BLK; r++) for (int q = 0; q < BLK; q++) curMem[r][q] = 8'd77;
    runCase();
    check(mvX == 0 && mvY == 0, "R4 full tie picks zero vector", int'(mvX)*100 + int'(mvY), 0);
    check(intraFlag == 1'b0, "R5 flat block stays inter", int'(intraFlag), 0);

    // C: two exact matches, raster order picks dy=-6 over dy=5
    randWindow();
    for (int r = 0; r < BLK; r++) for (int q = 0; q < BLK; q++) curMem[r][q] = 8'($urandom);
    plant(5, -1);
    plant(-6, 2);
    runCase();
    check(mvX == 2 && mvY == -6, "R4 tie resolved by scan order (x*100+y)",
          int'(mvX)*100 + int'(mvY), 2*100 - 6);

    // D: smooth block against noise -> intra
    randWindow();
    smoothCur();
    setNb(10, 20, 30, 3'b111, 0);
    runCase();
    check(intraFlag == 1'b1, "R5 smooth block intra", int'(intraFlag), 1);
    check(skipFine == 1'b0, "R6 all neighbours smaller -> no skip", int'(skipFine), 0);

    // E: large bias forces inter
    setNb(10, 20, 30, 3'b111, 16000);
    runCase();
    check(intraFlag == 1'b0, "R5 large bias keeps inter", int'(intraFlag), 0);

    // F: missing neighbour counts as maximal
    setNb(10, 20, 30, 3'b101, 0);
    runCase();
    check(skipFine == 1'b1, "R6 missing neighbour -> skip", int'(skipFine), 1);

    // G: inputs change and start repeats mid-run
    setNb(5, 5, 5, 3'b111, 16000);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (50) @(negedge clk);
    setNb(0, 0, 0, 3'b000, 0);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done) @(negedge clk);
    check(intraFlag == 1'b0 && skipFine == 1'b0, "R7 late input changes ignored",
          int'({intraFlag, skipFine}), 0);

    // H: start in the done cycle, results held through the next run
    keepSad = int'(minSad); keepDx = int'(mvX); keepDy = int'(mvY);
    randWindow();
    for (int r = 0; r < BLK; r++) for (int q = 0; q < BLK; q++) curMem[r][q] = refMem[-2+RANGE+r][9+RANGE+q];
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (LAT / 2) @(negedge clk);
    check(int'(minSad) == keepSad && int'(mvX) == keepDx && int'(mvY) == keepDy,
          "R8 results held during next run", int'(minSad), keepSad);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(mvX == 9 && mvY == -2, "R2 back-to-back run result (x*100+y)",
          int'(mvX)*100 + int'(mvY), 9*100 - 2);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule